// File: doc/BRIEF.md
# Timer Bank Register Controller

This block is the register front end for a bank of eight down-counting timer channels. It sits on a 32-bit word bus with separate read and write strobes and a byte-enable field. It decodes a 16-byte window for each channel and a block of four shared words. The counting logic of each channel lives in its own instance outside this block. The controller hands each channel its configuration bits, its reload and match values, and a load strobe. Each channel returns its live count and an interrupt event pulse.

The shared control word packs four configuration bits per channel. A write that changes several bits of a channel is applied over three clock edges. Enables that turn off go first. The clock-select, interrupt and pulse bits follow. Enables that turn on go last. A channel therefore never runs with a mix of old and new settings.

A sticky interrupt status word collects the channel events. A clear port masks bits off the control word, and it works only after a command word has unlocked it.

Top module: `tmrbank_top`

## Requirements
- R1: A synchronous active-low reset clears the control word, the unlock flag, the interrupt status word, and every channel's reload, match-A and match-B values. It also drops the load strobes.
- R2: Channel n (0-based) owns 16-byte window n for n < 3 and window n+1 for n >= 3, with window = address[11:4]. Inside a window, offset +0x4 is the reload value, +0x8 is match A and +0xC is match B. These values read back as written and drive the matching channel output one cycle after the write edge.
- R3: Offset +0x0 of a window reads the channel's live count input. Writing it gives a one-cycle pulse on that channel's load output, with the written value on the load value output in the same cycle.
- R4: Offset 0x30 is the control word, read as the currently applied value. Channel n uses bits [4n+3:4n]: bit 0 enable, bit 1 external clock select, bit 2 overflow interrupt enable, bit 3 pulse enable. After a write, enables going 1 to 0 take effect at the first edge, the other three bits at the second edge, and enables going 0 to 1 at the third edge.
- R5: The pulse enable bit stays 0 for channels 0 to 3, whatever is written. It can be set only on channels 4 to 7.
- R6: Writing 0x38 with data bits [8:1] equal to 0xAE sets the unlock flag, and 0xEA clears it. Any other value leaves the flag unchanged. Reading 0x38 returns the flag in bit 0.
- R7: While unlocked, a write to 0x3C clears every control bit that is 1 in the data, using the same three-step order as R4. While locked, such a write leaves the control word unchanged.
- R8: A channel's interrupt event sets bit n of the status word at 0x34, and the bit stays set. A write to 0x34 ANDs the status word with the data. An event arriving in the same cycle as that write still leaves its bit set.
- R9: Misaligned addresses, and windows above 8, read as zero and ignore writes.
- R10: An access whose byte enables are not all ones reads as zero and has no effect when written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rstN | input | 1 | Synchronous reset, active low |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busAddr | input | 12 | Byte address |
| busBe | input | 4 | Byte enables, must be 4'hF to decode |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from address |
| chanCount | input | 256 | Live count of each channel, 32 bits each |
| chanIrqEvt | input | 8 | Interrupt event pulse from each channel |
| chanEnable | output | 8 | Applied enable bit per channel |
| chanExtClk | output | 8 | Applied external clock select per channel |
| chanOvfIrq | output | 8 | Applied overflow interrupt enable per channel |
| chanPulse | output | 8 | Applied pulse enable per channel |
| chanReload | output | 256 | Reload value per channel |
| chanMatchA | output | 256 | First match value per channel |
| chanMatchB | output | 256 | Second match value per channel |
| chanLoad | output | 8 | One-cycle count load strobe per channel |
| chanLoadVal | output | 32 | Value carried with a load strobe |

## Verification
The bench uses the default build: eight channels, three low windows, and pulse support starting at channel 4. This places the hole at window 3 between the two channel groups, so both halves of the window-to-channel mapping get exercised. It also puts the pulse boundary inside the tested control word and makes the control word a full 32 bits, so the clear port and the pulse mask reach every bit. With one free-running model compared every cycle, the three-step control ordering is checked edge by edge, including a write that turns one channel off while it changes that channel's configuration.

// File: rtl/tmrbank_pkg.sv
package tmrbank_pkg;
  localparam int CHAN_IDX_W  = 4;
  localparam int BITS_PER_CH = 4;
  localparam int BIT_EN      = 0;
  localparam int BIT_EXT     = 1;
  localparam int BIT_OVF     = 2;
  localparam int BIT_PULSE   = 3;

  typedef enum logic [1:0] {
    WIN_COUNT   = 2'd0,
    WIN_RELOAD  = 2'd1,
    WIN_MATCH_A = 2'd2,
    WIN_MATCH_B = 2'd3
  } winWord_e;

  typedef enum logic [1:0] {
    SH_CTRL   = 2'd0,
    SH_STATUS = 2'd1,
    SH_LOCK   = 2'd2,
    SH_CLEAR  = 2'd3
  } sharedWord_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_CFG  = 2'd1,
    SEQ_EN   = 2'd2
  } seqPhase_e;

  // Decoded bus command handed from control to datapath
  typedef struct packed {
    logic                  chanHit;
    logic                  sharedHit;
    logic                  rd;
    logic                  wr;
    logic [CHAN_IDX_W-1:0] chan;
    winWord_e              word;
    sharedWord_e           sharedSel;
    logic [31:0]           data;
  } busCmd_t;
endpackage

// File: rtl/tmrbank_ctrl.sv
module tmrbank_ctrl
  import tmrbank_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int LOW_WINDOWS = 3,
  parameter int PULSE_FIRST = 4,
  parameter int ADDR_W      = 12
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          busRd,
  input  logic                          busWr,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic [3:0]                    busBe,
  input  logic [31:0]                   busWdata,
  output busCmd_t                       cmd,
  output logic [NUM_CH*BITS_PER_CH-1:0] ctrlWord,
  output logic                          unlocked
);
  localparam int CW    = NUM_CH * BITS_PER_CH;
  localparam int WIN_W = ADDR_W - 4;
  localparam logic [WIN_W-1:0] LOW_WIN = WIN_W'(LOW_WINDOWS);
  localparam logic [WIN_W-1:0] TOP_WIN = WIN_W'(NUM_CH);

  function automatic logic [CW-1:0] enPattern();
    logic [CW-1:0] p;
    p = '0;
    for (int c = 0; c < NUM_CH; c++) p[c*BITS_PER_CH+BIT_EN] = 1'b1;
    return p;
  endfunction

  function automatic logic [CW-1:0] writablePattern();
    logic [CW-1:0] p;
    p = '1;
    for (int c = 0; c < NUM_CH; c++)
      if (c < PULSE_FIRST) p[c*BITS_PER_CH+BIT_PULSE] = 1'b0;
    return p;
  endfunction

  localparam logic [CW-1:0] EN_BITS  = enPattern();
  localparam logic [CW-1:0] WR_MASK  = writablePattern();

  logic [WIN_W-1:0]      win;
  logic                  fullWord;
  logic                  chanHitC;
  logic                  sharedHitC;
  logic [CHAN_IDX_W-1:0] chanIdxC;
  sharedWord_e           sharedSelC;

  assign win        = busAddr[ADDR_W-1:4];
  assign sharedSelC = sharedWord_e'(busAddr[3:2]);

  always_comb begin
    fullWord   = (busBe == 4'hF) && (busAddr[1:0] == 2'b00);
    chanHitC   = 1'b0;
    sharedHitC = 1'b0;
    chanIdxC   = '0;
    if (fullWord) begin
      if (win < LOW_WIN) begin
        chanHitC = 1'b1;
        chanIdxC = CHAN_IDX_W'(win);
      end else if (win == LOW_WIN) begin
        sharedHitC = 1'b1;
      end else if (win <= TOP_WIN) begin
        chanHitC = 1'b1;
        chanIdxC = CHAN_IDX_W'(win - 1'b1);
      end
    end
  end

  always_comb begin
    cmd           = '0;
    cmd.chanHit   = chanHitC;
    cmd.sharedHit = sharedHitC;
    cmd.rd        = busRd;
    cmd.wr        = busWr;
    cmd.chan      = chanIdxC;
    cmd.word      = winWord_e'(busAddr[3:2]);
    cmd.sharedSel = sharedSelC;
    cmd.data      = busWdata;
  end

  // Control word sequencer: disable, then configure, then enable
  logic          ctrlWrHit;
  logic          clrWrHit;
  logic          lockWrHit;
  logic          startSeq;
  logic [CW-1:0] startTarget;
  logic [CW-1:0] target;
  seqPhase_e     phase;

  assign ctrlWrHit = busWr && sharedHitC && (sharedSelC == SH_CTRL);
  assign clrWrHit  = busWr && sharedHitC && (sharedSelC == SH_CLEAR);
  assign lockWrHit = busWr && sharedHitC && (sharedSelC == SH_LOCK);
  assign startSeq  = ctrlWrHit || (clrWrHit && unlocked);

  always_comb begin
    if (ctrlWrHit) startTarget = busWdata[CW-1:0] & WR_MASK;
    else           startTarget = ctrlWord & ~busWdata[CW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlWord <= '0;
      target   <= '0;
      phase    <= SEQ_IDLE;
      unlocked <= 1'b0;
    end else begin
      if (startSeq) begin
        ctrlWord <= ctrlWord & ~(EN_BITS & ~startTarget);
        target   <= startTarget;
        phase    <= SEQ_CFG;
      end else begin
        case (phase)
          SEQ_CFG: begin
            ctrlWord <= (ctrlWord & EN_BITS) | (target & ~EN_BITS);
            phase    <= SEQ_EN;
          end
          SEQ_EN: begin
            ctrlWord <= target;
            phase    <= SEQ_IDLE;
          end
          default: phase <= SEQ_IDLE;
        endcase
      end
      if (lockWrHit) begin
        if (busWdata[8:1] == 8'hAE)      unlocked <= 1'b1;
        else if (busWdata[8:1] == 8'hEA) unlocked <= 1'b0;
      end
    end
  end

  AST_EN_RISE_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (phase != SEQ_EN) |=> ((ctrlWord & EN_BITS & ~$past(ctrlWord)) == '0))
    else $error("enable rose outside the final step"); // R4

  AST_CFG_MIDDLE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (phase != SEQ_CFG) |=> ((ctrlWord & ~EN_BITS) == ($past(ctrlWord) & ~EN_BITS)))
    else $error("configuration bits moved outside the middle step"); // R4

  AST_LOCKED_CLEAR_NOP: assert property (@(posedge clk) disable iff (!rstN)
    (clrWrHit && !unlocked && phase == SEQ_IDLE) |=> $stable(ctrlWord))
    else $error("clear port acted while locked"); // R7

  AST_PARTIAL_WRITE_NOP: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busBe != 4'hF && phase == SEQ_IDLE) |=> ($stable(ctrlWord) && $stable(unlocked)))
    else $error("partial write changed shared state"); // R10
endmodule

// File: rtl/tmrbank_datapath.sv
module tmrbank_datapath
  import tmrbank_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  busCmd_t                       cmd,
  input  logic [NUM_CH*BITS_PER_CH-1:0] ctrlWord,
  input  logic                          unlocked,
  input  logic [NUM_CH*32-1:0]          chanCount,
  input  logic [NUM_CH-1:0]             chanIrqEvt,
  output logic [31:0]                   busRdata,
  output logic [NUM_CH*32-1:0]          chanReload,
  output logic [NUM_CH*32-1:0]          chanMatchA,
  output logic [NUM_CH*32-1:0]          chanMatchB,
  output logic [NUM_CH-1:0]             chanLoad,
  output logic [31:0]                   chanLoadVal
);
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [NUM_CH-1:0][31:0] reloadQ;
  logic [NUM_CH-1:0][31:0] matchAQ;
  logic [NUM_CH-1:0][31:0] matchBQ;
  logic [NUM_CH-1:0][31:0] countView;
  logic [NUM_CH-1:0]       loadQ;
  logic [31:0]             loadValQ;
  logic [NUM_CH-1:0]       irqSts;
  logic [IDX_W-1:0]        idx;
  logic                    chanWr;
  logic                    stsWr;

  assign idx       = cmd.chan[IDX_W-1:0];
  assign chanWr    = cmd.chanHit && cmd.wr;
  assign stsWr     = cmd.sharedHit && cmd.wr && (cmd.sharedSel == SH_STATUS);
  assign countView = chanCount;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadQ  <= '0;
      matchAQ  <= '0;
      matchBQ  <= '0;
      loadQ    <= '0;
      loadValQ <= '0;
      irqSts   <= '0;
    end else begin
      loadQ <= '0;
      if (chanWr) begin
        case (cmd.word)
          WIN_COUNT: begin
            loadQ[idx] <= 1'b1;
            loadValQ   <= cmd.data;
          end
          WIN_RELOAD:  reloadQ[idx] <= cmd.data;
          WIN_MATCH_A: matchAQ[idx] <= cmd.data;
          default:     matchBQ[idx] <= cmd.data;
        endcase
      end
      irqSts <= (stsWr ? (irqSts & cmd.data[NUM_CH-1:0]) : irqSts) | chanIrqEvt;
    end
  end

  assign chanReload  = reloadQ;
  assign chanMatchA  = matchAQ;
  assign chanMatchB  = matchBQ;
  assign chanLoad    = loadQ;
  assign chanLoadVal = loadValQ;

  always_comb begin
    busRdata = '0;
    if (cmd.rd && cmd.chanHit) begin
      case (cmd.word)
        WIN_COUNT:   busRdata = countView[idx];
        WIN_RELOAD:  busRdata = reloadQ[idx];
        WIN_MATCH_A: busRdata = matchAQ[idx];
        default:     busRdata = matchBQ[idx];
      endcase
    end else if (cmd.rd && cmd.sharedHit) begin
      case (cmd.sharedSel)
        SH_CTRL:   busRdata = 32'(ctrlWord);
        SH_STATUS: busRdata = 32'(irqSts);
        SH_LOCK:   busRdata = {31'b0, unlocked};
        default:   busRdata = '0;
      endcase
    end
  end

  AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rstN)
    (|chanIrqEvt) |=> ((~irqSts & $past(chanIrqEvt)) == '0))
    else $error("interrupt event lost"); // R8

  AST_STATUS_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    (irqSts & ~$past(irqSts) & ~$past(chanIrqEvt)) == '0)
    else $error("status bit set without an event"); // R8

  AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chanLoad))
    else $error("more than one load strobe"); // R3
endmodule

// File: rtl/tmrbank_top.sv
module tmrbank_top
  import tmrbank_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int LOW_WINDOWS = 3,
  parameter int PULSE_FIRST = 4,
  parameter int ADDR_W      = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busRd,
  input  logic                 busWr,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [3:0]           busBe,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  input  logic [NUM_CH*32-1:0] chanCount,
  input  logic [NUM_CH-1:0]    chanIrqEvt,
  output logic [NUM_CH-1:0]    chanEnable,
  output logic [NUM_CH-1:0]    chanExtClk,
  output logic [NUM_CH-1:0]    chanOvfIrq,
  output logic [NUM_CH-1:0]    chanPulse,
  output logic [NUM_CH*32-1:0] chanReload,
  output logic [NUM_CH*32-1:0] chanMatchA,
  output logic [NUM_CH*32-1:0] chanMatchB,
  output logic [NUM_CH-1:0]    chanLoad,
  output logic [31:0]          chanLoadVal
);
  localparam int CW = NUM_CH * BITS_PER_CH;

  busCmd_t       cmd;
  logic [CW-1:0] ctrlWord;
  logic          unlocked;

  tmrbank_ctrl #(
    .NUM_CH(NUM_CH), .LOW_WINDOWS(LOW_WINDOWS),
    .PULSE_FIRST(PULSE_FIRST), .ADDR_W(ADDR_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .busRd(busRd), .busWr(busWr),
    .busAddr(busAddr), .busBe(busBe), .busWdata(busWdata),
    .cmd(cmd), .ctrlWord(ctrlWord), .unlocked(unlocked)
  );

  tmrbank_datapath #(.NUM_CH(NUM_CH)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .ctrlWord(ctrlWord),
    .unlocked(unlocked), .chanCount(chanCount), .chanIrqEvt(chanIrqEvt),
    .busRdata(busRdata), .chanReload(chanReload), .chanMatchA(chanMatchA),
    .chanMatchB(chanMatchB), .chanLoad(chanLoad), .chanLoadVal(chanLoadVal)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_fanout
    assign chanEnable[c] = ctrlWord[c*BITS_PER_CH+BIT_EN];
    assign chanExtClk[c] = ctrlWord[c*BITS_PER_CH+BIT_EXT];
    assign chanOvfIrq[c] = ctrlWord[c*BITS_PER_CH+BIT_OVF];
    assign chanPulse[c]  = ctrlWord[c*BITS_PER_CH+BIT_PULSE];
  end
endmodule

// File: tb/tmrbank_tb_top.sv
module tmrbank_tb_top;
  localparam int NCH = 8;
  localparam logic [31:0] EN_MASK    = 32'h1111_1111;
  localparam logic [31:0] PULSE_MASK = 32'hFFFF_7777;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           busRd = 1'b0, busWr = 1'b0;
  logic [11:0]    busAddr = '0;
  logic [3:0]     busBe = 4'hF;
  logic [31:0]    busWdata = '0;
  logic [31:0]    busRdata;
  logic [NCH*32-1:0] chanCount;
  logic [NCH-1:0] chanIrqEvt = '0;
  logic [NCH-1:0] chanEnable, chanExtClk, chanOvfIrq, chanPulse, chanLoad;
  logic [NCH*32-1:0] chanReload, chanMatchA, chanMatchB;
  logic [31:0]    chanLoadVal;

  int nChecks = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  for (genvar c = 0; c < NCH; c++) begin : g_cnt
    assign chanCount[c*32 +: 32] = 32'hC0DE_0000 + c;
  end

  tmrbank_top dut_i (
    .clk(clk), .rstN(rstN), .busRd(busRd), .busWr(busWr), .busAddr(busAddr),
    .busBe(busBe), .busWdata(busWdata), .busRdata(busRdata),
    .chanCount(chanCount), .chanIrqEvt(chanIrqEvt), .chanEnable(chanEnable),
    .chanExtClk(chanExtClk), .chanOvfIrq(chanOvfIrq), .chanPulse(chanPulse),
    .chanReload(chanReload), .chanMatchA(chanMatchA), .chanMatchB(chanMatchB),
    .chanLoad(chanLoad), .chanLoadVal(chanLoadVal)
  );

  task automatic check(input logic [255:0] act, input logic [255:0] exp,
                       input string req, input string what);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [31:0] mCtrl, mTgt, mLoadVal;
  logic [7:0]  mSts, mLoad;
  logic        mUnlock;
  int          mPhase;
  logic [31:0] mReload [NCH];
  logic [31:0] mMa [NCH];
  logic [31:0] mMb [NCH];
  bit          modelValid = 0;

  always @(posedge clk) begin : refModel
    logic [31:0] tgt;
    int win, wd, ch;
    bit full, shared, start;
    if (!rstN) begin
      mCtrl = 0; mTgt = 0; mPhase = 0; mUnlock = 0; mSts = 0;
      mLoad = 0; mLoadVal = 0;
      for (int i = 0; i < NCH; i++) begin
        mReload[i] = 0; mMa[i] = 0; mMb[i] = 0;
      end
    end else begin
      full = (busBe == 4'hF) && (busAddr[1:0] == 2'b00);
      win = int'(busAddr >> 4);
      wd = int'(busAddr[3:2]);
      ch = -1; shared = 0;
      if (full) begin
        if (win < 3) ch = win;
        else if (win == 3) shared = 1;
        else if (win <= 8) ch = win - 1;
      end
      start = 0; tgt = 0;
      if (busWr && shared && wd == 0) begin start = 1; tgt = busWdata & PULSE_MASK; end
      if (busWr && shared && wd == 3 && mUnlock) begin start = 1; tgt = mCtrl & ~busWdata; end
      if (start) begin
        mCtrl = mCtrl & ~(EN_MASK & ~tgt); mTgt = tgt; mPhase = 1;
      end else if (mPhase == 1) begin
        mCtrl = (mCtrl & EN_MASK) | (mTgt & ~EN_MASK); mPhase = 2;
      end else if (mPhase == 2) begin
        mCtrl = mTgt; mPhase = 0;
      end
      if (busWr && shared && wd == 2) begin
        if (busWdata[8:1] == 8'hAE) mUnlock = 1;
        else if (busWdata[8:1] == 8'hEA) mUnlock = 0;
      end
      mSts = ((busWr && shared && wd == 1) ? (mSts & busWdata[7:0]) : mSts) | chanIrqEvt;
      mLoad = 0;
      if (busWr && ch >= 0) begin
        case (wd)
          0: begin mLoad[ch] = 1'b1; mLoadVal = busWdata; end
          1: mReload[ch] = busWdata;
          2: mMa[ch] = busWdata;
          default: mMb[ch] = busWdata;
        endcase
      end
    end
    modelValid = 1;
  end

  // Every-cycle comparison of registered outputs
  always @(negedge clk) begin : cmpOut
    logic [7:0] eEn, eExt, eOvf, ePul;
    logic [255:0] eRel, eMa, eMb;
    if (modelValid) begin
      for (int c = 0; c < NCH; c++) begin
        eEn[c] = mCtrl[4*c]; eExt[c] = mCtrl[4*c+1];
        eOvf[c] = mCtrl[4*c+2]; ePul[c] = mCtrl[4*c+3];
        eRel[c*32 +: 32] = mReload[c]; eMa[c*32 +: 32] = mMa[c]; eMb[c*32 +: 32] = mMb[c];
      end
      check(chanEnable, eEn, "R4", "chanEnable");
      check(chanExtClk, eExt, "R4", "chanExtClk");
      check(chanOvfIrq, eOvf, "R4", "chanOvfIrq");
      check(chanPulse, ePul, "R5", "chanPulse");
      check(chanReload, eRel, "R2", "chanReload");
      check(chanMatchA, eMa, "R2", "chanMatchA");
      check(chanMatchB, eMb, "R2", "chanMatchB");
      check(chanLoad, mLoad, "R3", "chanLoad");
      if (mLoad != 0) check(chanLoadVal, mLoadVal, "R3", "chanLoadVal");
    end
  end

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d,
                          input logic [3:0] be = 4'hF);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d; busBe = be;
    @(negedge clk);
    busWr = 1'b0; busBe = 4'hF;
  endtask

  task automatic readChk(input logic [11:0] a, input logic [31:0] exp,
                         input string req, input logic [3:0] be = 4'hF);
    @(negedge clk);
    busRd = 1'b1; busAddr = a; busBe = be;
    #5;
    check(busRdata, exp, req, $sformatf("read 0x%0h", a));
    busRd = 1'b0; busBe = 4'hF;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic pulseEvt(input logic [7:0] m);
    @(negedge clk); chanIrqEvt = m;
    @(negedge clk); chanIrqEvt = '0;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin : stim
    doReset();
    // R1: reset state
    readChk(12'h030, 32'h0, "R1");
    readChk(12'h034, 32'h0, "R1");
    readChk(12'h038, 32'h0, "R1");
    readChk(12'h004, 32'h0, "R1");
    readChk(12'h08C, 32'h0, "R1");
    check(chanLoad, 8'h0, "R1", "load after reset");

    // R2: windows on both sides of the shared block
    busWrite(12'h004, 32'h1111_0000);
    busWrite(12'h028, 32'h0000_2222);
    busWrite(12'h044, 32'h0000_3333);
    busWrite(12'h08C, 32'h0000_7777);
    readChk(12'h004, 32'h1111_0000, "R2");
    readChk(12'h028, 32'h0000_2222, "R2");
    readChk(12'h044, 32'h0000_3333, "R2");
    readChk(12'h08C, 32'h0000_7777, "R2");
    check(chanReload[3*32 +: 32], 32'h3333, "R2", "channel 3 reload pin");

    // R3: count word
    busWrite(12'h060, 32'h0000_ABCD);
    check(chanLoad, 8'h20, "R3", "load strobe");
    check(chanLoadVal, 32'hABCD, "R3", "load value");
    @(negedge clk);
    check(chanLoad, 8'h00, "R3", "load strobe drop");
    readChk(12'h060, 32'hC0DE_0005, "R3");
    readChk(12'h040, 32'hC0DE_0003, "R3");

    // R4: ordering, enabling with configuration
    busWrite(12'h030, 32'h0005_0003);
    check(chanEnable, 8'h00, "R4", "step1 enable");
    check(chanExtClk, 8'h00, "R4", "step1 ext");
    @(negedge clk);
    check(chanEnable, 8'h00, "R4", "step2 enable");
    check(chanExtClk, 8'h01, "R4", "step2 ext");
    check(chanOvfIrq, 8'h10, "R4", "step2 ovf");
    @(negedge clk);
    check(chanEnable, 8'h11, "R4", "step3 enable");
    readChk(12'h030, 32'h0005_0003, "R4");
    // R4: disabling with configuration
    busWrite(12'h030, 32'h0005_0004);
    check(chanEnable, 8'h10, "R4", "disable first");
    check(chanExtClk, 8'h01, "R4", "ext held at step1");
    @(negedge clk);
    check(chanExtClk, 8'h00, "R4", "ext at step2");
    check(chanOvfIrq, 8'h11, "R4", "ovf at step2");
    settle();
    readChk(12'h030, 32'h0005_0004, "R4");

    // R5: pulse bit only on upper channels
    busWrite(12'h030, 32'hFFFF_FFFF);
    settle();
    readChk(12'h030, 32'hFFFF_7777, "R5");
    check(chanPulse, 8'hF0, "R5", "pulse pins");

    // R6 / R7: lock and clear alias
    busWrite(12'h03C, 32'hFFFF_FFFF);
    settle();
    readChk(12'h030, 32'hFFFF_7777, "R7");
    readChk(12'h038, 32'h0, "R6");
    busWrite(12'h038, 32'h0000_015C);
    readChk(12'h038, 32'h1, "R6");
    busWrite(12'h038, 32'h0000_01FE);
    readChk(12'h038, 32'h1, "R6");
    busWrite(12'h03C, 32'h0000_0011);
    settle();
    readChk(12'h030, 32'hFFFF_7766, "R7");
    check(chanEnable, 8'hFC, "R7", "enables after clear");
    busWrite(12'h038, 32'h0000_01D4);
    readChk(12'h038, 32'h0, "R6");
    busWrite(12'h038, 32'h0000_00AE);
    readChk(12'h038, 32'h0, "R6");
    busWrite(12'h03C, 32'hFFFF_FFFF);
    settle();
    readChk(12'h030, 32'hFFFF_7766, "R7");

    // R8: sticky status
    pulseEvt(8'h42);
    readChk(12'h034, 32'h42, "R8");
    pulseEvt(8'h01);
    readChk(12'h034, 32'h43, "R8");
    busWrite(12'h034, 32'hFFFF_FFFD);
    readChk(12'h034, 32'h41, "R8");
    @(negedge clk);
    busWr = 1'b1; busAddr = 12'h034; busWdata = 32'h0; chanIrqEvt = 8'h80;
    @(negedge clk);
    busWr = 1'b0; chanIrqEvt = 8'h00;
    readChk(12'h034, 32'h80, "R8");
    busWrite(12'h034, 32'h0);
    readChk(12'h034, 32'h0, "R8");

    // R9: undefined offsets
    readChk(12'h090, 32'h0, "R9");
    readChk(12'h104, 32'h0, "R9");
    readChk(12'h005, 32'h0, "R9");
    busWrite(12'h094, 32'h0000_1234);
    readChk(12'h094, 32'h0, "R9");
    busWrite(12'h006, 32'h0000_DEAD);
    readChk(12'h004, 32'h1111_0000, "R9");

    // R10: partial byte enables
    busWrite(12'h004, 32'h0000_5555, 4'h3);
    readChk(12'h004, 32'h1111_0000, "R10");
    readChk(12'h004, 32'h0, "R10", 4'h1);
    busWrite(12'h030, 32'h0, 4'h7);
    settle();
    readChk(12'h030, 32'hFFFF_7766, "R10");

    // R1: reset while unlocked and configured
    busWrite(12'h038, 32'h0000_015C);
    pulseEvt(8'h04);
    doReset();
    readChk(12'h030, 32'h0, "R1");
    readChk(12'h034, 32'h0, "R1");
    readChk(12'h038, 32'h0, "R1");
    readChk(12'h004, 32'h0, "R1");
    check(chanEnable, 8'h0, "R1", "enables after reset");

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule